// File: doc/BRIEF.md
# Dual-Feed DC Power Supervisor

The block watches two DC supply feeds, feed 0 (primary) and feed 1 (secondary). For each feed it takes a voltage and a current reading from an external converter, each qualified by its own strobe. It keeps hysteresis state for under-voltage, over-voltage and over-current on each feed. It drives a bi-colour LED per feed and selects the secondary feed whenever the primary is faulty. Selection returns to the primary on its own once the fault has gone.

Selection of the secondary is reported on one level output, which does not say which fault caused it. Any newly raised alarm sets a sticky interrupt toward the host. The host clears the interrupt by writing 1 to a status bit. Thresholds, the current limit, the presence level and the per-feed masks sit in a small word-addressed register file.

Voltages are unsigned magnitudes in units of 10 mV on a 16-bit bus. Currents are unsigned in units of 10 mA.

Top module: `pwr_feed_supervisor`

## Requirements
- R1: After reset all alarms, `irq`, `on_secondary` and every LED output are 0. Registers read back 4000 (addr 0), 4200 (addr 1), 6000 (addr 2), 5800 (addr 3), 2000 (addr 4), 500 (addr 5), 0 (addr 6) and 0 (addr 7).
- R2: Under-voltage rises on a sample below the raise level (addr 0) and falls on a sample at or above the clear level (addr 1). Samples between the two levels keep the current state. The alarm is visible after the edge that takes the sample.
- R3: Over-voltage rises on a sample above the raise level (addr 2) and falls on a sample at or below the clear level (addr 3). Samples between the two levels keep the current state.
- R4: Over-current rises on a current sample above the limit L (addr 4) and falls at or below L - floor(L/20).
- R5: Writing addresses 0 to 5 replaces the corresponding level at run time. The new value reads back, and it governs every later sample.
- R6: Bit i of the control register (addr 6) masks feed i, so all three alarm outputs of that feed read 0. The LED of a masked feed still follows its voltage.
- R7: The hysteresis state of a feed changes only on a clock edge where that feed's sample strobe is high.
- R8: `on_secondary` is 1 one cycle after any alarm of feed 0 is set, and 0 one cycle after none is set. Alarms on feed 1 do not affect it. Status bit 1 (addr 7) reads it back.
- R9: The LED of a feed is off (`led_green` = `led_red` = 0) when the last voltage sample was below the presence level (addr 5). It is green when the feed is present and has neither a voltage alarm nor an over-voltage alarm, and red when the feed is present with a voltage alarm.
- R10: `irq` becomes 1 one cycle after any alarm output rises. It stays 1 until a write of 1 to bit 0 of addr 7. A new rise in the same cycle as the clearing write wins over the clear. Status bit 0 reads `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 2 | Sample strobe per feed |
| volt_a | input | 16 | Feed 0 voltage, 10 mV units |
| curr_a | input | 16 | Feed 0 current, 10 mA units |
| volt_b | input | 16 | Feed 1 voltage, 10 mV units |
| curr_b | input | 16 | Feed 1 current, 10 mA units |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| uv_alarm | output | 2 | Under-voltage alarm per feed |
| ov_alarm | output | 2 | Over-voltage alarm per feed |
| oc_alarm | output | 2 | Over-current alarm per feed |
| on_secondary | output | 1 | Secondary feed selected (failover notification) |
| irq | output | 1 | Sticky interrupt to host |
| led_green | output | 2 | Green LED drive per feed |
| led_red | output | 2 | Red LED drive per feed |

## Verification
The assertions assume that a sample strobe is a single-cycle qualifier. They also assume that register writes are not overlapped with a sample in a way that would need same-edge ordering, apart from the interrupt clear, whose precedence is defined.

The stimulus drives every input on the falling edge and holds a strobe for exactly one rising edge. It performs register writes only between samples. Each feed's readings therefore arrive as discrete events, and each alarm, selection and interrupt change can be tied to a single edge.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_UV_SET = 3'd0;
    localparam logic [ADDR_W-1:0] A_UV_CLR = 3'd1;
    localparam logic [ADDR_W-1:0] A_OV_SET = 3'd2;
    localparam logic [ADDR_W-1:0] A_OV_CLR = 3'd3;
    localparam logic [ADDR_W-1:0] A_OC_LIM = 3'd4;
    localparam logic [ADDR_W-1:0] A_PRES   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd7;

    localparam logic [DATA_W-1:0] DEF_UV_SET = 16'd4000;
    localparam logic [DATA_W-1:0] DEF_UV_CLR = 16'd4200;
    localparam logic [DATA_W-1:0] DEF_OV_SET = 16'd6000;
    localparam logic [DATA_W-1:0] DEF_OV_CLR = 16'd5800;
    localparam logic [DATA_W-1:0] DEF_OC_LIM = 16'd2000;
    localparam logic [DATA_W-1:0] DEF_PRES   = 16'd500;

    typedef struct packed {
        logic [DATA_W-1:0] uv_set;
        logic [DATA_W-1:0] uv_clr;
        logic [DATA_W-1:0] ov_set;
        logic [DATA_W-1:0] ov_clr;
        logic [DATA_W-1:0] oc_lim;
        logic [DATA_W-1:0] pres;
    } thr_t;

    typedef struct packed {
        logic present;
        logic uv;
        logic ov;
        logic oc;
    } feed_st_t;
endpackage

// File: rtl/pwr_sup_regs.sv
module pwr_sup_regs
    import pwr_sup_pkg::*;
#(
    parameter int N_FEED = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_set,
    input  logic              on_sec,
    output thr_t              thr,
    output logic [N_FEED-1:0] mask,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        thr_t              thr;
        logic [N_FEED-1:0] mask;
        logic              irq;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            unique case (addr)
                A_UV_SET: st_d.thr.uv_set = wdata;
                A_UV_CLR: st_d.thr.uv_clr = wdata;
                A_OV_SET: st_d.thr.ov_set = wdata;
                A_OV_CLR: st_d.thr.ov_clr = wdata;
                A_OC_LIM: st_d.thr.oc_lim = wdata;
                A_PRES:   st_d.thr.pres   = wdata;
                A_CTRL:   st_d.mask       = wdata[N_FEED-1:0];
                A_STAT:   if (wdata[0]) st_d.irq = 1'b0;
                default:  ;
            endcase
        end
        // a fresh alarm edge takes precedence over a clearing write
        if (irq_set) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr  <= '{uv_set: DEF_UV_SET, uv_clr: DEF_UV_CLR,
                           ov_set: DEF_OV_SET, ov_clr: DEF_OV_CLR,
                           oc_lim: DEF_OC_LIM, pres: DEF_PRES};
            st_q.mask <= '0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_UV_SET: rdata = st_q.thr.uv_set;
            A_UV_CLR: rdata = st_q.thr.uv_clr;
            A_OV_SET: rdata = st_q.thr.ov_set;
            A_OV_CLR: rdata = st_q.thr.ov_clr;
            A_OC_LIM: rdata = st_q.thr.oc_lim;
            A_PRES:   rdata = st_q.thr.pres;
            A_CTRL:   rdata[N_FEED-1:0] = st_q.mask;
            A_STAT:   rdata[1:0] = {on_sec, st_q.irq};
            default:  rdata = '0;
        endcase
    end

    assign thr  = st_q.thr;
    assign mask = st_q.mask;
    assign irq  = st_q.irq;
endmodule

// File: rtl/pwr_feed_monitor.sv
module pwr_feed_monitor
    import pwr_sup_pkg::*;
#(
    parameter int OC_HYST_DIV = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] volt,
    input  logic [DATA_W-1:0] curr,
    input  thr_t              thr,
    input  logic              mask,
    output logic              uv_alarm,
    output logic              ov_alarm,
    output logic              oc_alarm,
    output logic              led_green,
    output logic              led_red
);
    feed_st_t          st_d, st_q;
    logic [DATA_W-1:0] oc_clr;

    assign oc_clr = thr.oc_lim - (thr.oc_lim / DATA_W'(OC_HYST_DIV));

    always_comb begin
        st_d = st_q;
        if (smp_vld) begin
            st_d.present = (volt >= thr.pres);
            st_d.uv = st_q.uv ? (volt < thr.uv_clr) : (volt < thr.uv_set);
            st_d.ov = st_q.ov ? (volt > thr.ov_clr) : (volt > thr.ov_set);
            st_d.oc = st_q.oc ? (curr > oc_clr)     : (curr > thr.oc_lim);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Mask gates reporting only; the hysteresis state keeps tracking.
    assign uv_alarm  = st_q.uv & ~mask;
    assign ov_alarm  = st_q.ov & ~mask;
    assign oc_alarm  = st_q.oc & ~mask;
    assign led_green = st_q.present & ~(st_q.uv | st_q.ov);
    assign led_red   = st_q.present &  (st_q.uv | st_q.ov);
endmodule

// File: rtl/pwr_feed_supervisor.sv
module pwr_feed_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int OC_HYST_DIV = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  smp_vld,
    input  logic [15:0] volt_a,
    input  logic [15:0] curr_a,
    input  logic [15:0] volt_b,
    input  logic [15:0] curr_b,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [1:0]  uv_alarm,
    output logic [1:0]  ov_alarm,
    output logic [1:0]  oc_alarm,
    output logic        on_secondary,
    output logic        irq,
    output logic [1:0]  led_green,
    output logic [1:0]  led_red
);
    localparam int N_FEED = 2;
    localparam int N_ALM  = 3 * N_FEED;

    typedef struct packed {
        logic [N_ALM-1:0] alm_prev;
        logic             on_sec;
    } top_st_t;

    thr_t              thr;
    logic [N_FEED-1:0] ctrl_mask;
    logic [DATA_W-1:0] volt [N_FEED];
    logic [DATA_W-1:0] curr [N_FEED];
    logic [N_ALM-1:0]  alm_now;
    logic              irq_set;
    top_st_t           st_d, st_q;

    assign volt[0] = volt_a;
    assign volt[1] = volt_b;
    assign curr[0] = curr_a;
    assign curr[1] = curr_b;

    for (genvar g = 0; g < N_FEED; g++) begin : g_feed
        pwr_feed_monitor #(.OC_HYST_DIV(OC_HYST_DIV)) i_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_vld   (smp_vld[g]),
            .volt      (volt[g]),
            .curr      (curr[g]),
            .thr       (thr),
            .mask      (ctrl_mask[g]),
            .uv_alarm  (uv_alarm[g]),
            .ov_alarm  (ov_alarm[g]),
            .oc_alarm  (oc_alarm[g]),
            .led_green (led_green[g]),
            .led_red   (led_red[g])
        );
    end

    assign alm_now = {oc_alarm, ov_alarm, uv_alarm};
    assign irq_set = |(alm_now & ~st_q.alm_prev);

    always_comb begin
        st_d          = st_q;
        st_d.alm_prev = alm_now;
        st_d.on_sec   = uv_alarm[0] | ov_alarm[0] | oc_alarm[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_secondary = st_q.on_sec;

    pwr_sup_regs #(.N_FEED(N_FEED)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .irq_set (irq_set),
        .on_sec  (st_q.on_sec),
        .thr     (thr),
        .mask    (ctrl_mask),
        .irq     (irq),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/pwr_sup_checker.sv
module pwr_sup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] smp_vld,
    input logic [1:0] uv_alarm,
    input logic [1:0] ov_alarm,
    input logic [1:0] oc_alarm,
    input logic [1:0] led_green,
    input logic [1:0] led_red,
    input logic [1:0] mask,
    input logic       on_secondary,
    input logic       irq,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [15:0] reg_wdata
);
    logic prim_fault;
    logic irq_clr_wr;
    assign prim_fault = uv_alarm[0] | ov_alarm[0] | oc_alarm[0];
    assign irq_clr_wr = reg_we && (reg_addr == 3'd7) && reg_wdata[0];

    assert_failover_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prim_fault |=> on_secondary);
    assert_failover_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prim_fault |=> !on_secondary);
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr_wr) |=> irq);

    for (genvar g = 0; g < 2; g++) begin : g_chk
        assert_led_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({led_green[g], led_red[g]}));
        assert_mask_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            mask[g] |-> !(uv_alarm[g] || ov_alarm[g] || oc_alarm[g]));
        assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(smp_vld[g]) && $stable(mask[g])) |->
                ($stable(uv_alarm[g]) && $stable(ov_alarm[g]) && $stable(oc_alarm[g])));
    end
endmodule

bind pwr_feed_supervisor pwr_sup_checker i_pwr_sup_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_vld      (smp_vld),
    .uv_alarm     (uv_alarm),
    .ov_alarm     (ov_alarm),
    .oc_alarm     (oc_alarm),
    .led_green    (led_green),
    .led_red      (led_red),
    .mask         (ctrl_mask),
    .on_secondary (on_secondary),
    .irq          (irq),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata)
);

// File: tb/test_pwr_feed_supervisor.sv
module test_pwr_feed_supervisor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  smp_vld = '0;
    logic [15:0] volt_a = '0, curr_a = '0, volt_b = '0, curr_b = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  uv_alarm, ov_alarm, oc_alarm, led_green, led_red;
    logic        on_secondary, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_feed_supervisor i_pwr_feed_supervisor (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // one strobe, then two more edges so alarm, selection and irq have settled
    task automatic smp(int f, logic [15:0] v, logic [15:0] c);
        @(negedge clk);
        if (f == 0) begin volt_a = v; curr_a = c; end
        else        begin volt_b = v; curr_b = c; end
        smp_vld[f] = 1'b1;
        @(negedge clk);
        smp_vld = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 alarms", {uv_alarm, ov_alarm, oc_alarm}, 0);
        chk("R1 irq/sec", {irq, on_secondary}, 0);
        chk("R1 leds", {led_green, led_red}, 0);
        rd(3'd0, d); chk("R1 uv_set", d, 4000);
        rd(3'd1, d); chk("R1 uv_clr", d, 4200);
        rd(3'd2, d); chk("R1 ov_set", d, 6000);
        rd(3'd3, d); chk("R1 ov_clr", d, 5800);
        rd(3'd4, d); chk("R1 oc_lim", d, 2000);
        rd(3'd5, d); chk("R1 pres", d, 500);
        rd(3'd7, d); chk("R1 status", d, 0);
    endtask

    task automatic t_uv();
        smp(1, 4100, 100);
        chk("R2 no uv at 41V", uv_alarm[1], 0);
        chk("R9 green", {led_green[1], led_red[1]}, 2'b10);
        smp(1, 3999, 100);
        chk("R2 uv raised", uv_alarm[1], 1);
        chk("R10 irq set", irq, 1);
        chk("R9 red", {led_green[1], led_red[1]}, 2'b01);
        chk("R8 feed1 no failover", on_secondary, 0);
        smp(1, 4100, 100);
        chk("R2 uv held in band", uv_alarm[1], 1);
        smp(1, 4200, 100);
        chk("R2 uv cleared", uv_alarm[1], 0);
        chk("R10 irq sticky", irq, 1);
        wr(3'd7, 16'h0001);
        chk("R10 irq cleared", irq, 0);
    endtask

    task automatic t_ov();
        smp(1, 6000, 100);
        chk("R3 no ov at 60V", ov_alarm[1], 0);
        smp(1, 6001, 100);
        chk("R3 ov raised", ov_alarm[1], 1);
        smp(1, 5900, 100);
        chk("R3 ov held in band", ov_alarm[1], 1);
        smp(1, 5800, 100);
        chk("R3 ov cleared", ov_alarm[1], 0);
        wr(3'd7, 16'h0001);
    endtask

    task automatic t_oc();
        smp(1, 4800, 2000);
        chk("R4 no oc at limit", oc_alarm[1], 0);
        smp(1, 4800, 2001);
        chk("R4 oc raised", oc_alarm[1], 1);
        smp(1, 4800, 1901);
        chk("R4 oc held", oc_alarm[1], 1);
        smp(1, 4800, 1900);
        chk("R4 oc cleared", oc_alarm[1], 0);
        wr(3'd7, 16'h0001);
    endtask

    task automatic t_failover();
        logic [15:0] d;
        smp(0, 4800, 100);
        chk("R8 primary ok", on_secondary, 0);
        smp(0, 3000, 100);
        chk("R8 failover uv", on_secondary, 1);
        rd(3'd7, d); chk("R8 status bit1", d[1], 1);
        smp(0, 4800, 100);
        chk("R8 return", on_secondary, 0);
        smp(0, 4800, 2500);
        chk("R8 failover oc", on_secondary, 1);
        smp(0, 4800, 100);
        chk("R8 return oc", on_secondary, 0);
        wr(3'd7, 16'h0001);
        chk("R10 irq cleared", irq, 0);
    endtask

    task automatic t_presence();
        smp(0, 400, 0);
        chk("R9 absent off", {led_green[0], led_red[0]}, 2'b00);
        wr(3'd5, 300);
        smp(0, 400, 0);
        chk("R9 present red", {led_green[0], led_red[0]}, 2'b01);
        wr(3'd5, 500);
        smp(0, 4800, 0);
        chk("R9 back green", {led_green[0], led_red[0]}, 2'b10);
        wr(3'd7, 16'h0001);
    endtask

    task automatic t_mask();
        wr(3'd6, 16'h0002);
        smp(1, 3000, 100);
        chk("R6 masked uv", uv_alarm[1], 0);
        chk("R6 no irq", irq, 0);
        chk("R6 led red", led_red[1], 1);
        smp(1, 4800, 100);
        wr(3'd6, 16'h0000);
        chk("R6 unmasked quiet", uv_alarm[1], 0);
    endtask

    task automatic t_thresh();
        logic [15:0] d;
        wr(3'd0, 4500);
        wr(3'd1, 4700);
        rd(3'd0, d); chk("R5 readback", d, 4500);
        smp(1, 4400, 100);
        chk("R5 new uv level", uv_alarm[1], 1);
        smp(1, 4600, 100);
        chk("R5 new clr level held", uv_alarm[1], 1);
        smp(1, 4700, 100);
        chk("R5 new clr level", uv_alarm[1], 0);
        wr(3'd0, 4000);
        wr(3'd1, 4200);
        wr(3'd7, 16'h0001);
    endtask

    task automatic t_strobe();
        smp(1, 3000, 100);
        chk("R7 feed1 uv", uv_alarm[1], 1);
        smp(0, 4800, 100);
        chk("R7 other strobe", uv_alarm[1], 1);
        @(negedge clk); volt_b = 5000;
        repeat (3) @(negedge clk);
        chk("R7 no strobe", uv_alarm[1], 1);
        smp(1, 5000, 100);
        chk("R7 strobe clears", uv_alarm[1], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uv();
        t_ov();
        t_oc();
        t_failover();
        t_presence();
        t_mask();
        t_thresh();
        t_strobe();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule